// File: doc/BRIEF.md
# Access Permission Failure Capture Unit

This block sits beside the filter units of a memory access security controller. It records the details of an access that fails its check in a filter. A failure can be a region permission failure or a region overlap failure. For each filter unit it latches the 64-bit address, the direction, the security and privilege attributes, the transaction ID and the virtual network number. It also raises a per-filter interrupt status flag.

Only the first failure after reset, or after software last cleared that filter's flag, is kept. While the flag is set, that filter's capture set stays frozen. Software reads the captured values through a simple combinational register read port and re-arms a filter by writing a one to its bit of the clear input. The per-filter action setting is accepted as an input, but it never decides whether a capture takes place.

Top module: `fail_capture_unit`

## Requirements
- R1: After reset every status flag is 0 and every register offset reads 0.
- R2: Filter x has four words at byte offset 0x020 + 0x10*x: +0x0 address low, +0x4 address high, +0x8 control, +0xC ID. An offset with nonzero bits 1:0, below 0x020, or for a filter at or above NF reads 0.
- R3: The address-low word holds captured address bits 31:0, and the address-high word holds bits 63:32.
- R4: The control word has bit 24 = direction (1 write, 0 read), bit 21 = 1 for a Non-secure access and bit 20 = 1 for a privileged access. All other bits read 0.
- R5: The ID word holds the virtual network number in bits 27:24 (zero-extended from VN_W bits). It holds the transaction ID zero-extended from ID_W bits in bits 23:0. Bits 31:28 read 0.
- R6: A failure event on a filter whose flag is clear loads that filter's capture set and sets its flag at the same clock edge. The new values are readable from the following cycle.
- R7: While a filter's flag is set and no clear is applied, further failures in that filter leave its four words unchanged.
- R8: A 1 in bit x of the clear input clears flag x at the next edge and re-arms capture. A 0 bit leaves its flag unchanged. Clearing does not alter the captured words.
- R9: When a clear and a failure reach the same filter in the same cycle, the clear is applied first: the failure is captured and the flag stays 1.
- R10: A region overlap failure is captured exactly like a permission failure. If both are reported in one cycle, one capture of that cycle's attributes is made.
- R11: The per-filter action setting has no effect on capture or on the status flags.
- R12: Reading any offset has no side effect on flags or captured words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| perm_fail | input | NF | Per-filter region permission failure strobe |
| ovlp_fail | input | NF | Per-filter region overlap failure strobe |
| fail_addr | input | NF*64 | Per-filter access address, filter x at bits 64x+63:64x |
| fail_write | input | NF | Per-filter direction, 1 = write |
| fail_nonsec | input | NF | Per-filter Non-secure attribute |
| fail_priv | input | NF | Per-filter privileged attribute |
| fail_id | input | NF*ID_W | Per-filter transaction ID |
| fail_vn | input | NF*VN_W | Per-filter virtual network number |
| act_cfg | input | NF*2 | Per-filter action setting, does not gate capture |
| irq_clr | input | NF | Write-one-to-clear strobe, one bit per filter |
| irq_flag | output | NF | Per-filter interrupt status flag |
| rd_addr | input | RA_W | Register byte offset |
| rd_data | output | 32 | Combinational read data |

## Verification
On every cycle the assertions check the flag sequencing. A failure on a clear flag sets it, a lone clear drops it, and a clear arriving with a failure leaves it set. An idle, clear flag stays clear. While a flag is held, the capture set stays frozen. A failure under the no-interrupt action setting still raises the flag. The assertions cannot check the register map, the bit placement of control and ID fields, the zero-extension, or the rejection of out-of-range offsets. The bench scenarios show these by comparing every readable word against a model built from the map.

// File: rtl/fcap_pkg.sv
package fcap_pkg;

  localparam int WORD_W     = 32;
  localparam int FADDR_W    = 64;
  localparam int BASE_OFF   = 32'h20;
  localparam int STRIDE_LG2 = 4;
  localparam int DIR_BIT    = 24;
  localparam int NS_BIT     = 21;
  localparam int PRIV_BIT   = 20;
  localparam int VN_LSB     = 24;
  localparam int VN_FIELD_W = 4;
  localparam int ID_FIELD_W = 24;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_CTRL    = 2'd2,
    W_IDENT   = 2'd3
  } word_sel_e;

  function automatic logic [WORD_W-1:0] pack_ctrl(input logic wr, input logic ns,
                                                  input logic pv);
    logic [WORD_W-1:0] w;
    w = '0;
    w[DIR_BIT]  = wr;
    w[NS_BIT]   = ns;
    w[PRIV_BIT] = pv;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_ident(input logic [VN_FIELD_W-1:0] vn,
                                                   input logic [ID_FIELD_W-1:0] id);
    logic [WORD_W-1:0] w;
    w = '0;
    w[VN_LSB +: VN_FIELD_W] = vn;
    w[ID_FIELD_W-1:0]       = id;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pick_word(input logic [FADDR_W-1:0] a,
                                                  input logic [WORD_W-1:0] ctrl,
                                                  input logic [WORD_W-1:0] ident,
                                                  input word_sel_e sel);
    case (sel)
      W_ADDR_LO: return a[WORD_W-1:0];
      W_ADDR_HI: return a[FADDR_W-1:WORD_W];
      W_CTRL:    return ctrl;
      default:   return ident;
    endcase
  endfunction

endpackage

// File: rtl/fcap_slot.sv
module fcap_slot
  import fcap_pkg::*;
#(
  parameter int ID_W = 16,
  parameter int VN_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ev_perm,
  input  logic                   ev_ovlp,
  input  logic [FADDR_W-1:0]     ev_addr,
  input  logic                   ev_write,
  input  logic                   ev_nonsec,
  input  logic                   ev_priv,
  input  logic [ID_W-1:0]        ev_id,
  input  logic [VN_W-1:0]        ev_vn,
  input  logic                   clr,
  output logic                   flag,
  output logic                   ev_hit,
  output logic                   cap_en,
  output logic [3:0][WORD_W-1:0] words
);

  logic [FADDR_W-1:0] addr_q;
  logic               write_q, ns_q, priv_q;
  logic [ID_W-1:0]    id_q;
  logic [VN_W-1:0]    vn_q;
  logic               flag_q;

  logic [ID_FIELD_W-1:0] id_ext;
  logic [VN_FIELD_W-1:0] vn_ext;

  assign ev_hit = ev_perm | ev_ovlp;
  assign cap_en = ev_hit & (~flag_q | clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (ev_hit) begin
      flag_q <= 1'b1;
    end else if (clr) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      ns_q    <= 1'b0;
      priv_q  <= 1'b0;
      id_q    <= '0;
      vn_q    <= '0;
    end else if (cap_en) begin
      addr_q  <= ev_addr;
      write_q <= ev_write;
      ns_q    <= ev_nonsec;
      priv_q  <= ev_priv;
      id_q    <= ev_id;
      vn_q    <= ev_vn;
    end
  end

  always_comb begin
    id_ext = '0;
    vn_ext = '0;
    id_ext[ID_W-1:0] = id_q;
    vn_ext[VN_W-1:0] = vn_q;
  end

  assign flag = flag_q;

  for (genvar w = 0; w < 4; w++) begin : g_word
    assign words[w] = pick_word(addr_q, pack_ctrl(write_q, ns_q, priv_q),
                                pack_ident(vn_ext, id_ext), word_sel_e'(w));
  end

endmodule

// File: rtl/fcap_rdmux.sv
module fcap_rdmux
  import fcap_pkg::*;
#(
  parameter int NF   = 4,
  parameter int RA_W = 12
) (
  input  logic [RA_W-1:0]                rd_addr,
  input  logic [NF-1:0][3:0][WORD_W-1:0] slot_words,
  output logic [WORD_W-1:0]              rd_data,
  output logic                           rd_hit
);

  localparam int IDX_W = RA_W - STRIDE_LG2;

  logic [RA_W-1:0]  rel;
  logic [IDX_W-1:0] idx;
  logic [1:0]       sel;

  always_comb begin
    rel     = rd_addr - RA_W'(BASE_OFF);
    idx     = rel[RA_W-1:STRIDE_LG2];
    sel     = rel[3:2];
    rd_hit  = (rd_addr[1:0] == 2'b00) && (rd_addr >= RA_W'(BASE_OFF)) &&
              (32'(idx) < NF);
    rd_data = '0;
    for (int f = 0; f < NF; f++) begin
      if (rd_hit && (32'(idx) == f)) rd_data = slot_words[f][sel];
    end
  end

endmodule

// File: rtl/fail_capture_unit.sv
module fail_capture_unit
  import fcap_pkg::*;
#(
  parameter int NF   = 4,
  parameter int ID_W = 16,
  parameter int VN_W = 4,
  parameter int RA_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NF-1:0]        perm_fail,
  input  logic [NF-1:0]        ovlp_fail,
  input  logic [NF*FADDR_W-1:0] fail_addr,
  input  logic [NF-1:0]        fail_write,
  input  logic [NF-1:0]        fail_nonsec,
  input  logic [NF-1:0]        fail_priv,
  input  logic [NF*ID_W-1:0]   fail_id,
  input  logic [NF*VN_W-1:0]   fail_vn,
  input  logic [NF*2-1:0]      act_cfg,
  input  logic [NF-1:0]        irq_clr,
  output logic [NF-1:0]        irq_flag,
  input  logic [RA_W-1:0]      rd_addr,
  output logic [WORD_W-1:0]    rd_data
);

  logic [NF-1:0]                ev_hit;
  logic [NF-1:0]                cap_en;
  logic [NF-1:0][3:0][WORD_W-1:0] slot_words;
  logic                         rd_hit;

  for (genvar f = 0; f < NF; f++) begin : g_slot
    fcap_slot #(.ID_W(ID_W), .VN_W(VN_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_perm   (perm_fail[f]),
      .ev_ovlp   (ovlp_fail[f]),
      .ev_addr   (fail_addr[f*FADDR_W +: FADDR_W]),
      .ev_write  (fail_write[f]),
      .ev_nonsec (fail_nonsec[f]),
      .ev_priv   (fail_priv[f]),
      .ev_id     (fail_id[f*ID_W +: ID_W]),
      .ev_vn     (fail_vn[f*VN_W +: VN_W]),
      .clr       (irq_clr[f]),
      .flag      (irq_flag[f]),
      .ev_hit    (ev_hit[f]),
      .cap_en    (cap_en[f]),
      .words     (slot_words[f])
    );
  end

  fcap_rdmux #(.NF(NF), .RA_W(RA_W)) u_rdmux (
    .rd_addr    (rd_addr),
    .slot_words (slot_words),
    .rd_data    (rd_data),
    .rd_hit     (rd_hit)
  );

endmodule

// File: rtl/fcap_chk.sv
module fcap_chk
  import fcap_pkg::*;
#(
  parameter int NF = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NF-1:0]                ev_hit,
  input logic [NF-1:0]                irq_clr,
  input logic [NF-1:0]                irq_flag,
  input logic [NF*2-1:0]              act_cfg,
  input logic [NF-1:0][3:0][WORD_W-1:0] slot_words,
  input logic [WORD_W-1:0]            rd_data,
  input logic                         rd_hit
);

  for (genvar i = 0; i < NF; i++) begin : g_chk
    a_r6_fail_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ev_hit[i] |=> irq_flag[i]);

    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag[i] && !irq_clr[i]) |=> $stable(slot_words[i]));

    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr[i] && !ev_hit[i]) |=> !irq_flag[i]);

    a_r8_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_flag[i] && !ev_hit[i]) |=> !irq_flag[i]);

    a_r9_clear_with_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr[i] && ev_hit[i]) |=> irq_flag[i]);

    a_r11_no_irq_still_captures: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_hit[i] && !irq_flag[i] && act_cfg[2*i +: 2] == 2'b00) |=> irq_flag[i]);
  end

  a_r2_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> rd_data == '0);

endmodule

bind fail_capture_unit fcap_chk #(.NF(NF)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_hit     (ev_hit),
  .irq_clr    (irq_clr),
  .irq_flag   (irq_flag),
  .act_cfg    (act_cfg),
  .slot_words (slot_words),
  .rd_data    (rd_data),
  .rd_hit     (rd_hit)
);

// File: tb/sim_fail_capture_unit.sv
`timescale 1ns/100ps
module sim_fail_capture_unit;

  localparam int NF   = 4;
  localparam int ID_W = 16;
  localparam int VN_W = 4;
  localparam int RA_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NF-1:0]      perm_fail = '0, ovlp_fail = '0, fail_write = '0;
  logic [NF-1:0]      fail_nonsec = '0, fail_priv = '0, irq_clr = '0;
  logic [NF*64-1:0]   fail_addr = '0;
  logic [NF*ID_W-1:0] fail_id = '0;
  logic [NF*VN_W-1:0] fail_vn = '0;
  logic [NF*2-1:0]    act_cfg = '0;
  logic [RA_W-1:0]    rd_addr = '0;
  logic [NF-1:0]      irq_flag;
  logic [31:0]        rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [NF-1:0] m_flag;
  logic [63:0]   m_addr [NF];
  logic [31:0]   m_ctrl [NF];
  logic [31:0]   m_idw  [NF];

  always #5 clk = ~clk;

  fail_capture_unit #(.NF(NF), .ID_W(ID_W), .VN_W(VN_W), .RA_W(RA_W)) u0 (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [RA_W-1:0] a);
    int off, f;
    off = int'(a);
    if (off < 32 || (off % 4) != 0) return 32'h0;
    f = (off - 32) / 16;
    if (f >= NF) return 32'h0;
    case (((off - 32) % 16) / 4)
      0: return m_addr[f][31:0];
      1: return m_addr[f][63:32];
      2: return m_ctrl[f];
      default: return m_idw[f];
    endcase
  endfunction

  function automatic logic [31:0] ctrl_of(logic w, logic ns, logic pv);
    return (32'(w) << 24) | (32'(ns) << 21) | (32'(pv) << 20);
  endfunction

  function automatic logic [31:0] idw_of(logic [VN_W-1:0] vn, logic [ID_W-1:0] id);
    return (32'(vn) << 24) | 32'(id);
  endfunction

  // Update model from the inputs held across the edge just taken.
  task automatic model_edge();
    for (int f = 0; f < NF; f++) begin
      logic ev;
      ev = perm_fail[f] | ovlp_fail[f];
      if (ev && (!m_flag[f] || irq_clr[f])) begin
        m_addr[f] = fail_addr[f*64 +: 64];
        m_ctrl[f] = ctrl_of(fail_write[f], fail_nonsec[f], fail_priv[f]);
        m_idw[f]  = idw_of(fail_vn[f*VN_W +: VN_W], fail_id[f*ID_W +: ID_W]);
      end
      if (ev) m_flag[f] = 1'b1;
      else if (irq_clr[f]) m_flag[f] = 1'b0;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
  endtask

  task automatic check_all(string tag);
    chk({tag, " flags"}, 32'(irq_flag), 32'(m_flag));
    for (int f = 0; f < NF; f++) begin
      for (int w = 0; w < 4; w++) begin
        rd_addr = RA_W'(32 + 16 * f + 4 * w);
        #0.2;
        chk(tag, rd_data, exp_read(rd_addr));
      end
    end
  endtask

  task automatic idle_inputs();
    perm_fail = '0; ovlp_fail = '0; irq_clr = '0;
  endtask

  task automatic set_ev(int f, logic [63:0] a, logic w, logic ns, logic pv,
                        logic [ID_W-1:0] id, logic [VN_W-1:0] vn);
    fail_addr[f*64 +: 64]     = a;
    fail_write[f]             = w;
    fail_nonsec[f]            = ns;
    fail_priv[f]              = pv;
    fail_id[f*ID_W +: ID_W]   = id;
    fail_vn[f*VN_W +: VN_W]   = vn;
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_flag = '0;
    for (int f = 0; f < NF; f++) begin
      m_addr[f] = '0; m_ctrl[f] = '0; m_idw[f] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state, R2 every offset in range including gaps
    chk("R1 flags after reset", 32'(irq_flag), 32'h0);
    for (int a = 0; a < 128; a += 4) begin
      rd_addr = RA_W'(a); #0.2;
      chk("R1 reset read", rd_data, 32'h0);
    end

    // R6 R11: capture with no-interrupt action on filter 0
    @(negedge clk);
    act_cfg = '0;
    set_ev(0, 64'hFC00_0001_ABCD_0000, 1'b1, 1'b1, 1'b0, 16'hBEEF, 4'h5);
    perm_fail[0] = 1'b1;
    step();
    check_all("R6 R11 first capture");
    rd_addr = RA_W'(12'h020); #0.2; chk("R3 addr low", rd_data, 32'hABCD_0000);
    rd_addr = RA_W'(12'h024); #0.2; chk("R3 addr high", rd_data, 32'hFC00_0001);
    rd_addr = RA_W'(12'h028); #0.2; chk("R4 ctrl", rd_data, 32'h0120_0000);
    rd_addr = RA_W'(12'h02C); #0.2; chk("R5 ident", rd_data, 32'h0500_BEEF);
    // R12 repeated read
    #0.2; chk("R12 reread", rd_data, 32'h0500_BEEF);

    // R7 frozen while flag set
    @(negedge clk);
    set_ev(0, 64'h1111_2222_3333_4444, 1'b0, 1'b0, 1'b1, 16'h1234, 4'hA);
    step();
    check_all("R7 frozen");
    rd_addr = RA_W'(12'h028); #0.2; chk("R7 ctrl kept", rd_data, 32'h0120_0000);

    // R8 clear with zeros elsewhere; filter 1 captured first so its flag must survive
    @(negedge clk);
    idle_inputs();
    set_ev(1, 64'h0000_0000_DEAD_0000, 1'b0, 1'b1, 1'b1, 16'hD00D, 4'h2);
    ovlp_fail[1] = 1'b1;           // R10 overlap path
    step();
    check_all("R10 overlap capture");
    @(negedge clk);
    idle_inputs();
    irq_clr = 4'b0001;
    step();
    chk("R8 cleared flag0 kept flag1", 32'(irq_flag), 32'h2);
    check_all("R8 clear keeps words");

    // R9 same-cycle clear and failure on filter 1
    @(negedge clk);
    idle_inputs();
    set_ev(1, 64'h0000_0007_0000_0100, 1'b1, 1'b0, 1'b0, 16'h00FF, 4'hF);
    perm_fail[1] = 1'b1; irq_clr[1] = 1'b1;
    step();
    chk("R9 flag stays", 32'(irq_flag[1]), 32'h1);
    rd_addr = RA_W'(12'h03C); #0.2; chk("R9 new ident", rd_data, 32'h0F00_00FF);

    // R10 both strobes at once on filter 2, action set to drive
    @(negedge clk);
    idle_inputs();
    act_cfg = '1;
    set_ev(2, 64'h0000_0003_0000_0ABC, 1'b0, 1'b1, 1'b0, 16'h4242, 4'h8);
    perm_fail[2] = 1'b1; ovlp_fail[2] = 1'b1;
    step();
    check_all("R10 both strobes");

    // R2 out-of-range and misaligned offsets
    rd_addr = RA_W'(12'h060); #0.2; chk("R2 beyond NF", rd_data, 32'h0);
    rd_addr = RA_W'(12'h01C); #0.2; chk("R2 below base", rd_data, 32'h0);
    rd_addr = RA_W'(12'h022); #0.2; chk("R2 misaligned", rd_data, 32'h0);
    rd_addr = RA_W'(12'h046); #0.2; chk("R2 misaligned f2", rd_data, 32'h0);

    // Random phase: R6 R7 R8 R9 R10 R11 R12
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      for (int f = 0; f < NF; f++) begin
        set_ev(f, {$urandom, $urandom}, 1'($urandom), 1'($urandom), 1'($urandom),
               ID_W'($urandom), VN_W'($urandom));
        perm_fail[f] = ($urandom % 100) < 30;
        ovlp_fail[f] = ($urandom % 100) < 10;
        irq_clr[f]   = ($urandom % 100) < 25;
      end
      act_cfg = NF*2'($urandom);
      step();
      check_all("R7 R8 R9 random");
    end

    @(negedge clk);
    idle_inputs();
    step();
    check_all("R12 final");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule